// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation tree kept in ordinary memory. A translation cache in front of it hands over an address that missed, together with a flag saying whether the access is a write. The walker then reads one directory entry and one leaf entry through a single-outstanding read port. It returns either the physical address or a fault that names the cause and the level where the walk stopped.

Pages are 4 KB, and every table fills exactly one page of 1024 four-byte entries. The root register supplies the page frame of the directory. Bits 31:22 of the virtual address index the directory and bits 21:12 index the leaf table. Bits 11:0 pass through to the physical address unchanged.

A non-present entry at either level ends the walk with a not-present fault, which lets software fill the page on demand. A write through an entry that does not grant writes ends the walk with a protection fault. By default this check is made at both levels.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `ready_o` is 1 and `mem_req_o`, `done_o` and `fault_o` are 0.
- R2: The first read of a walk targets the root frame (`table_base_i[31:12]`) followed by `va[31:22]` and then two zero bits.
- R3: The second read targets bits 31:12 of the directory entry, followed by `va[21:12]` and then two zero bits.
- R4: A successful walk reports `pa_o` as bits 31:12 of the leaf entry joined with `va[11:0]`, and `fault_kind_o` is 0.
- R5: A directory entry with bit 0 (present) clear ends the walk after one read. It raises `fault_o` with `fault_kind_o` = 1 (not present) and `fault_level_o` = 0.
- R6: A leaf entry with bit 0 clear raises `fault_o` with `fault_kind_o` = 1 and `fault_level_o` = 1.
- R7: A write access through a present entry whose bit 1 (write allowed) is clear raises `fault_kind_o` = 2 (protection) at that entry's level. At the directory level the walk stops after one read. A read access never raises a protection fault.
- R8: An entry that is both non-present and write-denied reports not-present (1), never protection.
- R9: `mem_req_o` is a one-cycle pulse, and no new read is issued until the previous read has been answered by `mem_rsp_valid_i`.
- R10: `done_o` and `fault_o` are never high together. Each lasts exactly one cycle per walk, and `ready_o` returns high in the following cycle.
- R11: A walk is accepted only while `ready_o` is high. A request made during a walk is ignored: it produces no extra reads and no extra result.
- R12: The walker waits for a response of any latency and produces the same result whatever the latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| table_base_i | input | 32 | Root register; bits 31:12 give the directory frame |
| walk_req_i | input | 1 | Start a walk (taken only while ready) |
| walk_va_i | input | 32 | Virtual address to translate |
| walk_write_i | input | 1 | 1 when the access is a write |
| ready_o | output | 1 | Walker idle and able to accept a walk |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 32 | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Entry read from memory |
| done_o | output | 1 | One-cycle pulse: translation complete |
| fault_o | output | 1 | One-cycle pulse: walk ended in a fault |
| fault_kind_o | output | 2 | 0 none, 1 not present, 2 protection |
| fault_level_o | output | 1 | Level of the faulting entry (0 directory, 1 leaf) |
| pa_o | output | 32 | Physical address, valid with `done_o` |

## Verification
Several properties are checked on every cycle. The read request is a single pulse with at most one read in flight, and the result pulses are exclusive and short. `ready_o` is low whenever a read is issued, and a fault always carries a non-zero cause. Other behaviour only the directed scenarios can show. These are the entry addresses computed from the root and the indices, the joined physical address, and the stop after a single read on an upper-level fault. They also cover the order in which faults take priority, results under a slow memory, and requests that arrive mid-walk being dropped.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_DIR,
      ST_WT_DIR,
      ST_RD_LEAF,
      ST_WT_LEAF,
      ST_DONE,
      ST_FAULT
   } walk_state_e;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_ABSENT = 2'd1,
      FLT_PROT   = 2'd2
   } fault_e;

   localparam int PRESENT_BIT = 0;
   localparam int WRITE_BIT   = 1;

endpackage

// File: rtl/ptw_idx_addr.sv
module ptw_idx_addr #(
   parameter int ADDR_W    = 32,
   parameter int PAGE_BITS = 12,
   parameter int IDX_BITS  = 10
) (
   input  logic [ADDR_W-PAGE_BITS-1:0] table_frame_i,
   input  logic [IDX_BITS-1:0]         index_i,
   output logic [ADDR_W-1:0]           entry_addr_o
);
   localparam int SHIFT = PAGE_BITS - IDX_BITS;

   assign entry_addr_o = {table_frame_i, index_i, {SHIFT{1'b0}}};
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
   import ptw_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int PAGE_BITS = 12
) (
   input  logic [ADDR_W-1:0]           entry_i,
   input  logic                        is_write_i,
   input  logic                        perm_en_i,
   output logic                        present_o,
   output logic                        denied_o,
   output logic [ADDR_W-PAGE_BITS-1:0] frame_o
);
   assign present_o = entry_i[PRESENT_BIT];
   assign denied_o  = perm_en_i & is_write_i & ~entry_i[WRITE_BIT];
   assign frame_o   = entry_i[ADDR_W-1:PAGE_BITS];
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int PAGE_BITS  = 12,
   parameter int ENTRY_W    = 32,
   parameter bit UPPER_PERM = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [VA_W-1:0] table_base_i,
   input  logic            walk_req_i,
   input  logic [VA_W-1:0] walk_va_i,
   input  logic            walk_write_i,
   output logic            ready_o,
   output logic            mem_req_o,
   output logic [VA_W-1:0] mem_addr_o,
   input  logic            mem_rsp_valid_i,
   input  logic [VA_W-1:0] mem_rsp_data_i,
   output logic            done_o,
   output logic            fault_o,
   output logic [1:0]      fault_kind_o,
   output logic            fault_level_o,
   output logic [VA_W-1:0] pa_o
);
   localparam int ENTRY_BYTES = ENTRY_W / 8;
   localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
   localparam int IDX_BITS    = PAGE_BITS - ENTRY_SHIFT;
   localparam int FRAME_W     = VA_W - PAGE_BITS;
   localparam int DIR_LSB     = PAGE_BITS + IDX_BITS;

   generate
      if (PAGE_BITS + 2 * IDX_BITS != VA_W) begin : g_bad_split
         $error("two table levels plus the page offset must cover VA_W");
      end
      if (ENTRY_W != VA_W) begin : g_bad_entry
         $error("entry width must equal address width");
      end
      if ((1 << ENTRY_SHIFT) != ENTRY_BYTES) begin : g_bad_bytes
         $error("entry size must be a power of two bytes");
      end
   endgenerate

   walk_state_e         st_q;
   logic [VA_W-1:0]     va_q;
   logic                wr_q;
   logic [FRAME_W-1:0]  tbl_q;
   logic [VA_W-1:0]     pa_q;
   fault_e              kind_q;
   logic                lvl_q;

   logic [IDX_BITS-1:0] idx_sel;
   logic                ent_present;
   logic                ent_denied;
   logic [FRAME_W-1:0]  ent_frame;
   logic                perm_en;

   assign idx_sel = (st_q == ST_RD_DIR) ? va_q[VA_W-1:DIR_LSB]
                                        : va_q[DIR_LSB-1:PAGE_BITS];

   ptw_idx_addr #(
      .ADDR_W   (VA_W),
      .PAGE_BITS(PAGE_BITS),
      .IDX_BITS (IDX_BITS)
   ) u_addr (
      .table_frame_i(tbl_q),
      .index_i      (idx_sel),
      .entry_addr_o (mem_addr_o)
   );

   generate
      if (UPPER_PERM) begin : g_perm_both
         assign perm_en = 1'b1;
      end else begin : g_perm_leaf
         assign perm_en = (st_q == ST_WT_LEAF);
      end
   endgenerate

   ptw_entry_eval #(
      .ADDR_W   (VA_W),
      .PAGE_BITS(PAGE_BITS)
   ) u_eval (
      .entry_i   (mem_rsp_data_i),
      .is_write_i(wr_q),
      .perm_en_i (perm_en),
      .present_o (ent_present),
      .denied_o  (ent_denied),
      .frame_o   (ent_frame)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         va_q   <= '0;
         wr_q   <= 1'b0;
         tbl_q  <= '0;
         pa_q   <= '0;
         kind_q <= FLT_NONE;
         lvl_q  <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (walk_req_i) begin
                  va_q   <= walk_va_i;
                  wr_q   <= walk_write_i;
                  tbl_q  <= table_base_i[VA_W-1:PAGE_BITS];
                  kind_q <= FLT_NONE;
                  lvl_q  <= 1'b0;
                  st_q   <= ST_RD_DIR;
               end
            end
            ST_RD_DIR:  st_q <= ST_WT_DIR;
            ST_RD_LEAF: st_q <= ST_WT_LEAF;
            ST_WT_DIR, ST_WT_LEAF: begin
               if (mem_rsp_valid_i) begin
                  if (!ent_present) begin
                     kind_q <= FLT_ABSENT;
                     lvl_q  <= (st_q == ST_WT_LEAF);
                     st_q   <= ST_FAULT;
                  end else if (ent_denied) begin
                     kind_q <= FLT_PROT;
                     lvl_q  <= (st_q == ST_WT_LEAF);
                     st_q   <= ST_FAULT;
                  end else if (st_q == ST_WT_DIR) begin
                     tbl_q <= ent_frame;
                     st_q  <= ST_RD_LEAF;
                  end else begin
                     pa_q <= {ent_frame, va_q[PAGE_BITS-1:0]};
                     st_q <= ST_DONE;
                  end
               end
            end
            ST_DONE, ST_FAULT: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign ready_o       = (st_q == ST_IDLE);
   assign mem_req_o     = (st_q == ST_RD_DIR) || (st_q == ST_RD_LEAF);
   assign done_o        = (st_q == ST_DONE);
   assign fault_o       = (st_q == ST_FAULT);
   assign fault_kind_o  = kind_q;
   assign fault_level_o = lvl_q;
   assign pa_o          = pa_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ready_o,
   input logic       mem_req_o,
   input logic       mem_rsp_valid_i,
   input logic       done_o,
   input logic       fault_o,
   input logic [1:0] fault_kind_o
);
   logic in_flight;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               in_flight <= 1'b0;
      else if (mem_req_o)       in_flight <= 1'b1;
      else if (mem_rsp_valid_i) in_flight <= 1'b0;
   end

   assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |=> !mem_req_o);

   assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> !in_flight);

   assert_result_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && fault_o));

   assert_result_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || fault_o) |=> !(done_o || fault_o));

   assert_ready_after_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || fault_o) |=> ready_o);

   assert_busy_while_reading_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> !ready_o);

   assert_fault_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (fault_kind_o == 2'd1 || fault_kind_o == 2'd2));

   assert_done_no_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (fault_kind_o == 2'd0));
endmodule

bind ptw_walker ptw_walker_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .ready_o        (ready_o),
   .mem_req_o      (mem_req_o),
   .mem_rsp_valid_i(mem_rsp_valid_i),
   .done_o         (done_o),
   .fault_o        (fault_o),
   .fault_kind_o   (fault_kind_o)
);

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] table_base = 32'h0010_0000;
   logic        walk_req = 1'b0;
   logic [31:0] walk_va = '0;
   logic        walk_write = 1'b0;
   logic        ready, mem_req, mem_rsp_valid, done, fault, fault_level;
   logic [31:0] mem_addr, mem_rsp_data, pa;
   logic [1:0]  fault_kind;

   int          n_checks = 0;
   int          n_fail = 0;
   int          n_reads = 0;
   logic [31:0] rd_log [4];
   int          lat = 0;
   logic        pend = 1'b0;
   int          cnt = 0;
   logic [31:0] pend_addr = '0;
   logic [31:0] mem [logic [31:0]];

   always #2.5 clk = ~clk;

   ptw_walker u0 (
      .clk(clk), .rst_n(rst_n), .table_base_i(table_base),
      .walk_req_i(walk_req), .walk_va_i(walk_va), .walk_write_i(walk_write),
      .ready_o(ready), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
      .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data),
      .done_o(done), .fault_o(fault), .fault_kind_o(fault_kind),
      .fault_level_o(fault_level), .pa_o(pa)
   );

   // memory model: answers each read after lat extra cycles
   always @(posedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (mem_req) begin
         if (n_reads < 4) rd_log[n_reads] = mem_addr;
         n_reads = n_reads + 1;
         pend <= 1'b1;
         pend_addr <= mem_addr;
         cnt <= lat;
      end else if (pend) begin
         if (cnt == 0) begin
            pend <= 1'b0;
            mem_rsp_valid <= 1'b1;
            mem_rsp_data <= mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
         end else begin
            cnt <= cnt - 1;
         end
      end
   end

   initial begin
      #1_000_000;
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] dir_addr(input logic [31:0] base, input logic [31:0] va);
      return {base[31:12], 12'h000} + ((va >> 22) << 2);
   endfunction
   function automatic logic [31:0] leaf_addr(input logic [31:0] dent, input logic [31:0] va);
      return {dent[31:12], 12'h000} + (((va >> 12) & 32'h3FF) << 2);
   endfunction

   // runs one walk, leaves outputs sampled at the result pulse
   task automatic walk(input logic [31:0] va, input bit wr, output bit got_done, output bit got_fault);
      int t = 0;
      n_reads = 0;
      @(negedge clk);
      walk_va = va; walk_write = wr; walk_req = 1'b1;
      @(negedge clk);
      walk_req = 1'b0;
      while (!done && !fault && t < 500) begin
         @(negedge clk);
         t++;
      end
      got_done = done;
      got_fault = fault;
   endtask

   task automatic t_reset();
      chk(ready == 1'b1, "R1 ready", {31'b0, ready}, 32'h1);
      chk(!mem_req && !done && !fault, "R1 idle outputs", {29'b0, mem_req, done, fault}, 32'h0);
   endtask

   task automatic t_ok(input logic [31:0] va, input bit wr, input string tag);
      bit d, f;
      logic [31:0] dent, lent;
      dent = 32'h0020_0003;
      lent = 32'h0ABC_D003;
      mem[dir_addr(table_base, va)] = dent;
      mem[leaf_addr(dent, va)] = lent;
      walk(va, wr, d, f);
      chk(d && !f, {tag, " R4 done"}, {30'b0, d, f}, 32'h2);
      chk(pa == {lent[31:12], va[11:0]}, {tag, " R4 pa"}, pa, {lent[31:12], va[11:0]});
      chk(fault_kind == 2'd0, {tag, " R4 kind"}, {30'b0, fault_kind}, 32'h0);
      chk(n_reads == 2, {tag, " R9 reads"}, n_reads, 32'd2);
      chk(rd_log[0] == dir_addr(table_base, va), {tag, " R2 dir addr"}, rd_log[0], dir_addr(table_base, va));
      chk(rd_log[1] == leaf_addr(dent, va), {tag, " R3 leaf addr"}, rd_log[1], leaf_addr(dent, va));
      @(negedge clk);
      chk(!done && ready, {tag, " R10 pulse then ready"}, {30'b0, done, ready}, 32'h1);
   endtask

   task automatic t_fault(input logic [31:0] va, input bit wr, input logic [31:0] dent,
                          input logic [31:0] lent, input logic [1:0] ekind, input bit elvl,
                          input string tag);
      bit d, f;
      int ereads;
      mem[dir_addr(table_base, va)] = dent;
      mem[leaf_addr(dent, va)] = lent;
      ereads = elvl ? 2 : 1;
      walk(va, wr, d, f);
      chk(f && !d, {tag, " fault pulse"}, {30'b0, d, f}, 32'h1);
      chk(fault_kind == ekind, {tag, " kind"}, {30'b0, fault_kind}, {30'b0, ekind});
      chk(fault_level == elvl, {tag, " level"}, {31'b0, fault_level}, {31'b0, elvl});
      repeat (3) @(negedge clk);
      chk(n_reads == ereads, {tag, " read count"}, n_reads, ereads);
   endtask

   task automatic t_busy_ignored();
      bit d;
      int t = 0;
      int extra = 0;
      logic [31:0] va = 32'h1234_5678;
      logic [31:0] dent = 32'h0020_0003;
      logic [31:0] lent = 32'h0055_5001;
      mem[dir_addr(table_base, va)] = dent;
      mem[leaf_addr(dent, va)] = lent;
      lat = 3;
      n_reads = 0;
      @(negedge clk);
      walk_va = va; walk_write = 1'b0; walk_req = 1'b1;
      @(negedge clk);
      walk_va = 32'hFFC0_0000; walk_req = 1'b1;   // held during the walk
      chk(!ready, "R11 busy not ready", {31'b0, ready}, 32'h0);
      while (!done && !fault && t < 500) begin
         @(negedge clk);
         t++;
      end
      walk_req = 1'b0;
      d = done;
      chk(d && pa == {lent[31:12], va[11:0]}, "R11 first walk result", pa, {lent[31:12], va[11:0]});
      chk(n_reads == 2, "R11 no extra reads", n_reads, 32'd2);
      repeat (10) begin
         @(negedge clk);
         if (done || fault || mem_req) extra++;
      end
      chk(extra == 0 && ready, "R11 no extra walk", extra, 32'd0);
      lat = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      // R2 R3 R4: read and write through permissive entries, differing indices
      t_ok(32'h1234_5678, 1'b0, "read A");
      t_ok(32'hFFFF_FFFF, 1'b1, "write B");
      t_ok(32'h0000_0000, 1'b0, "read C");
      table_base = 32'h0300_0ABC;   // low bits of root ignored
      t_ok(32'h8040_1123, 1'b0, "root D");
      // R12: slow memory, same result
      lat = 7;
      t_ok(32'h1234_5678, 1'b1, "R12 latency");
      lat = 0;
      table_base = 32'h0010_0000;
      // R5: directory not present
      t_fault(32'h0440_0000, 1'b0, 32'h0020_0002, 32'h0ABC_D003, 2'd1, 1'b0, "R5 dir absent");
      // R6: leaf not present
      t_fault(32'h0480_1000, 1'b0, 32'h0030_0003, 32'h0ABC_D002, 2'd1, 1'b1, "R6 leaf absent");
      // R7: write through read-only directory, then leaf
      t_fault(32'h04C0_2000, 1'b1, 32'h0040_0001, 32'h0ABC_D003, 2'd2, 1'b0, "R7 dir prot");
      t_fault(32'h0500_3000, 1'b1, 32'h0050_0003, 32'h0ABC_D001, 2'd2, 1'b1, "R7 leaf prot");
      // R7: read through read-only entries succeeds
      begin
         bit d, f;
         logic [31:0] va = 32'h0540_4ABC;
         mem[dir_addr(table_base, va)] = 32'h0060_0001;
         mem[leaf_addr(32'h0060_0001, va)] = 32'h0077_7001;
         walk(va, 1'b0, d, f);
         chk(d && !f && pa == 32'h0077_7ABC, "R7 read of read-only", pa, 32'h0077_7ABC);
      end
      // R8: write through non-present, non-writable entry
      t_fault(32'h0580_5000, 1'b1, 32'h0070_0000, 32'h0ABC_D003, 2'd1, 1'b0, "R8 dir priority");
      t_fault(32'h05C0_6000, 1'b1, 32'h0080_0003, 32'h0ABC_D000, 2'd1, 1'b1, "R8 leaf priority");
      t_busy_ignored();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule